// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target end of a serial programming port inside a small microcontroller. A host holds the port-select pin `prog_rst_n` low to open a session. It then clocks 32-bit instructions in over `mosi` using its own serial clock `sck`. The block samples `sck`, `mosi` and `prog_rst_n` with the system clock. It accepts a serial clock edge only after the level before it has lasted a minimum number of system clocks. It returns data on `miso`.

Two storage arrays sit behind the port. The first is a 512-word by 16-bit program array with word addresses. The second is a 64-byte data array with its own byte address space. The host can read either array, write one byte, or erase both arrays to all-ones. Every instruction other than the unlock instruction is ignored until an unlock has been accepted in the current session. Each write or erase starts a self-timed busy window. Further writes and erases are refused while that window is open.

Top module: `isp_target`

## Requirements
- R1: The port is active only while `prog_rst_n` is low. Raising it ends the session, clears the unlock state and the partial frame, and `miso` then stays 0.
- R2: Within a session, no erase, write or read takes effect until an unlock instruction has been accepted. A read before the unlock returns 0x00.
- R3: An instruction is 32 bits, most significant bit first. Byte 0 is the opcode, bytes 1 and 2 are the address (byte 1 high), and byte 3 is write data or read data.
- R4: A `mosi` bit is taken at each accepted rising `sck` edge. `miso` changes only at accepted falling edges, so the host reads bit n just before the nth rising edge.
- R5: A rising edge is accepted only after `sck` has been high for at least HIGH_MIN (default 5) system clocks. A falling edge is accepted only after `sck` has been low for at least LOW_MIN (default 2) system clocks. A shorter high pulse is ignored completely.
- R6: Bytes 0xAC 0x53 in positions 0 and 1 form the unlock instruction. During byte 2 of that instruction `miso` returns 0x53. Any other byte 1 after 0xAC gives no echo.
- R7: Opcode 0x20 reads the low byte and 0x28 the high byte of the program word. The word address is the low 9 bits of {byte1, byte2}, and higher address bits are ignored.
- R8: Opcode 0x40 (low byte) or 0x48 (high byte) writes a program byte. The new value is the old value ANDed with the data, so bits can only be cleared.
- R9: Opcode 0xC0 writes the data byte at address byte2[5:0], replacing the old value outright. Opcode 0xA0 reads it. Higher address bits are ignored.
- R10: Bytes 0xAC 0x80 in positions 0 and 1 erase the chip: every program word becomes 0xFFFF and every data byte becomes 0xFF.
- R11: An accepted write or erase keeps the block busy for WR_CYCLES system clocks. Write and erase instructions that complete in that window are dropped. Reads are still served.
- R12: `miso` is 0 during bytes 0 and 1, and during byte 3 of any instruction that is not an accepted read. During byte 3 of an accepted read it carries the read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| prog_rst_n | input | 1 | Port select from the host, low opens a programming session |
| sck | input | 1 | Serial clock from the host, asynchronous to `clk` |
| mosi | input | 1 | Serial instruction data from the host |
| miso | output | 1 | Serial response data to the host |

## Verification
The serial inputs pass two synchronizer flops. A falling edge is therefore accepted about LOW_MIN+2 system clocks after `sck` drops, and the response bit reaches `miso` one clock later. A rising edge is accepted about HIGH_MIN+2 clocks after `sck` rises. An instruction acts on the arrays one clock after its 32nd accepted rising edge. The busy window then runs WR_CYCLES clocks. The host model holds each `sck` phase for 8 clocks and reads `miso` on the last clock of the low phase, after the update has settled. It leaves more than WR_CYCLES clocks after a write before sending the next write, except in the test that expects a write to be dropped. Session-end effects are sampled five clocks after `prog_rst_n` rises, which clears the synchronizer.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  localparam logic [7:0] OP_UNLOCK = 8'hAC;
  localparam logic [7:0] KEY_UNLK  = 8'h53;
  localparam logic [7:0] KEY_ERASE = 8'h80;
  localparam logic [7:0] OP_RDP_LO = 8'h20;
  localparam logic [7:0] OP_RDP_HI = 8'h28;
  localparam logic [7:0] OP_WRP_LO = 8'h40;
  localparam logic [7:0] OP_WRP_HI = 8'h48;
  localparam logic [7:0] OP_RDD    = 8'hA0;
  localparam logic [7:0] OP_WRD    = 8'hC0;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_UNLOCK, CMD_ERASE, CMD_WRP, CMD_WRD
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] key);
    cmd_e c;
    c = CMD_NONE;
    case (op)
      OP_UNLOCK: begin
        if (key == KEY_UNLK)       c = CMD_UNLOCK;
        else if (key == KEY_ERASE) c = CMD_ERASE;
      end
      OP_WRP_LO, OP_WRP_HI: c = CMD_WRP;
      OP_WRD:               c = CMD_WRD;
      default:              c = CMD_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/isp_sck_filter.sv
module isp_sck_filter #(
  parameter int LOW_MIN  = 2,
  parameter int HIGH_MIN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sess,
  input  logic sck_s,
  output logic rise,
  output logic fall
);
  localparam int CMAX = (HIGH_MIN > LOW_MIN) ? HIGH_MIN : LOW_MIN;
  localparam int RW   = $clog2(CMAX + 1);

  logic          prev_q, acc_q, acc_d;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    if (sck_s != prev_q)       run_d = RW'(1);
    else if (run_q < RW'(CMAX)) run_d = run_q + RW'(1);
    else                       run_d = run_q;
    rise = sess &&  sck_s && !acc_q && (run_d >= RW'(HIGH_MIN));
    fall = sess && !sck_s &&  acc_q && (run_d >= RW'(LOW_MIN));
    if (!sess)     acc_d = 1'b0;
    else if (rise) acc_d = 1'b1;
    else if (fall) acc_d = 1'b0;
    else           acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      acc_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= sck_s;
      acc_q  <= acc_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
  import isp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sess,
  input  logic                   rise,
  input  logic                   fall,
  input  logic                   mosi_s,
  input  logic [7:0]             resp,
  output logic [CNT_W-1:0]       cnt,
  output logic [23:0]            rx_lo,
  output logic                   frame_done,
  output logic [FRAME_BITS-1:0]  frame_word,
  output logic                   tx_bit
);
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d, word_q, word_d;
  logic [7:0]            tx_q, tx_d;
  logic                  done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    word_d = word_q;
    done_d = 1'b0;
    if (!sess) begin
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = '0;
    end else begin
      if (rise) begin
        rx_d  = {rx_q[FRAME_BITS-2:0], mosi_s};
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
          done_d = 1'b1;
          word_d = {rx_q[FRAME_BITS-2:0], mosi_s};
        end
      end
      if (fall) begin
        if (cnt_q[2:0] == 3'd0) tx_d = resp;
        else                    tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      word_q <= word_d;
      done_q <= done_d;
    end
  end

  assign cnt        = cnt_q;
  assign rx_lo      = rx_q[23:0];
  assign frame_done = done_q;
  assign frame_word = word_q;
  assign tx_bit     = tx_q[7];
endmodule

// File: rtl/isp_mem.sv
module isp_mem #(
  parameter int P_DEPTH = 512,
  parameter int D_DEPTH = 64,
  localparam int PAW = $clog2(P_DEPTH),
  localparam int DAW = $clog2(D_DEPTH)
) (
  input  logic           clk,
  input  logic           erase,
  input  logic           p_we,
  input  logic           p_hi,
  input  logic [PAW-1:0] p_wa,
  input  logic [7:0]     p_wd,
  input  logic           d_we,
  input  logic [DAW-1:0] d_wa,
  input  logic [7:0]     d_wd,
  input  logic [PAW-1:0] p_ra,
  output logic [15:0]    p_rd,
  input  logic [DAW-1:0] d_ra,
  output logic [7:0]     d_rd
);
  logic [15:0] parr [P_DEPTH];
  logic [7:0]  darr [D_DEPTH];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < P_DEPTH; i++) parr[i] <= 16'hFFFF;
      for (int j = 0; j < D_DEPTH; j++) darr[j] <= 8'hFF;
    end else begin
      if (p_we) begin
        if (p_hi) parr[p_wa][15:8] <= parr[p_wa][15:8] & p_wd;
        else      parr[p_wa][7:0]  <= parr[p_wa][7:0]  & p_wd;
      end
      if (d_we) darr[d_wa] <= d_wd;
    end
  end

  assign p_rd = parr[p_ra];
  assign d_rd = darr[d_ra];
endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int P_DEPTH   = 512,
  parameter int D_DEPTH   = 64,
  parameter int LOW_MIN   = 2,
  parameter int HIGH_MIN  = 5,
  parameter int WR_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int PAW = $clog2(P_DEPTH);
  localparam int DAW = $clog2(D_DEPTH);
  localparam int BW  = $clog2(WR_CYCLES + 1);

  logic                  prst_s, sck_s, mosi_s, sess;
  logic                  rise, fall, frame_done, tx_bit;
  logic [CNT_W-1:0]      cnt;
  logic [23:0]           rx_lo;
  logic [FRAME_BITS-1:0] frame_word;
  logic [7:0]            resp;
  logic [15:0]           rd_addr, p_rd;
  logic [7:0]            d_rd;
  cmd_e                  cmd;
  logic                  en_q, en_d, accept, erase, p_we, d_we, mem_we, busy;
  logic [BW-1:0]         busy_q, busy_d;

  isp_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({prog_rst_n, sck, mosi}), .q({prst_s, sck_s, mosi_s})
  );
  assign sess = !prst_s;

  isp_sck_filter #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) filt_i (
    .clk(clk), .rst_n(rst_n), .sess(sess), .sck_s(sck_s), .rise(rise), .fall(fall)
  );

  isp_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .sess(sess), .rise(rise), .fall(fall), .mosi_s(mosi_s),
    .resp(resp), .cnt(cnt), .rx_lo(rx_lo), .frame_done(frame_done),
    .frame_word(frame_word), .tx_bit(tx_bit)
  );

  assign rd_addr = rx_lo[15:0];

  isp_mem #(.P_DEPTH(P_DEPTH), .D_DEPTH(D_DEPTH)) mem_i (
    .clk(clk), .erase(erase),
    .p_we(p_we), .p_hi(frame_word[27]), .p_wa(frame_word[8 +: PAW]), .p_wd(frame_word[7:0]),
    .d_we(d_we), .d_wa(frame_word[8 +: DAW]), .d_wd(frame_word[7:0]),
    .p_ra(rd_addr[PAW-1:0]), .p_rd(p_rd), .d_ra(rd_addr[DAW-1:0]), .d_rd(d_rd)
  );

  // response byte loaded at the byte boundary, from bytes already received
  always_comb begin
    resp = 8'h00;
    if (cnt == CNT_W'(16) && rx_lo[15:0] == {OP_UNLOCK, KEY_UNLK}) begin
      resp = KEY_UNLK;
    end else if (cnt == CNT_W'(24) && en_q) begin
      case (rx_lo[23:16])
        OP_RDP_LO: resp = p_rd[7:0];
        OP_RDP_HI: resp = p_rd[15:8];
        OP_RDD:    resp = d_rd;
        default:   resp = 8'h00;
      endcase
    end
  end

  // execute a completed frame
  always_comb begin
    cmd    = decode_cmd(frame_word[31:24], frame_word[23:16]);
    busy   = (busy_q != '0);
    accept = frame_done && en_q && !busy;
    erase  = accept && (cmd == CMD_ERASE);
    p_we   = accept && (cmd == CMD_WRP);
    d_we   = accept && (cmd == CMD_WRD);
    mem_we = erase || p_we || d_we;
    if (!sess)                                en_d = 1'b0;
    else if (frame_done && cmd == CMD_UNLOCK) en_d = 1'b1;
    else                                      en_d = en_q;
    if (mem_we)    busy_d = BW'(WR_CYCLES);
    else if (busy) busy_d = busy_q - BW'(1);
    else           busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= '0;
    end else begin
      en_q   <= en_d;
      busy_q <= busy_d;
    end
  end

  assign miso = sess && tx_bit;
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk #(
  parameter int LOW_MIN  = 2,
  parameter int HIGH_MIN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic sess,
  input logic sck_s,
  input logic rise,
  input logic fall,
  input logic frame_done,
  input logic miso,
  input logic en_q,
  input logic busy,
  input logic mem_we
);
  localparam int CMAX = (HIGH_MIN > LOW_MIN) ? HIGH_MIN : LOW_MIN;
  int hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= sck_s  ? ((hi_run < CMAX) ? hi_run + 1 : hi_run) : 0;
      lo_run <= !sck_s ? ((lo_run < CMAX) ? lo_run + 1 : lo_run) : 0;
    end
  end

  assert_miso_idle_R1: assert property (@(posedge clk) disable iff (!rst_n) !sess |-> !miso);
  assert_unlock_drop_R1: assert property (@(posedge clk) disable iff (!rst_n) !sess |=> !en_q);
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> en_q);
  assert_frame_R3: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> $past(rise));
  assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n) rise |-> hi_run >= HIGH_MIN - 1);
  assert_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n) fall |-> lo_run >= LOW_MIN - 1);
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> busy);
endmodule

bind isp_target isp_target_chk #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .sess(sess), .sck_s(sck_s), .rise(rise), .fall(fall),
  .frame_done(frame_done), .miso(miso), .en_q(en_q), .busy(busy), .mem_we(mem_we)
);

// File: tb/isp_target_tb_top.sv
`timescale 1ns/1ps
module isp_target_tb_top;
  localparam int LOW  = 8;
  localparam int HIGH = 8;
  localparam int WAIT_WR = 1100;

  logic clk, rst_n, prog_rst_n, sck, mosi, miso;
  int n_chk, n_err;
  bit done;

  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  string       req_q[$];

  isp_target dut_i (
    .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares captured responses against queued expectations
  always @(negedge clk) begin
    if (got_q.size() > 0) begin
      logic [31:0] g, e;
      string r;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(g === e, r, g, e);
    end
  end

  task automatic shift_bits(input logic [31:0] w, input int n, input bit glitch, output logic [31:0] cap);
    cap = '0;
    for (int i = 31; i > 31 - n; i--) begin
      sck  = 1'b0;
      mosi = w[i];
      if (glitch && i == 20) begin
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
      end
      repeat (LOW) @(negedge clk);
      cap[i] = miso;
      sck = 1'b1;
      repeat (HIGH) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, input logic [7:0] e2, e3,
                       input string req, input bit glitch);
    logic [31:0] cap;
    exp_q.push_back({16'h0000, e2, e3});
    req_q.push_back(req);
    shift_bits({b0, b1, b2, b3}, 32, glitch, cap);
    sck = 1'b0;
    repeat (6) @(negedge clk);
    got_q.push_back(cap);
  endtask

  initial begin
    logic [31:0] cap;
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; prog_rst_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    check(miso === 1'b0, "R1 reset state", {31'b0, miso}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(miso === 1'b0, "R1 idle with port closed", {31'b0, miso}, 32'h0);

    // session 1
    prog_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 8'h53, 8'h00, "R6 unlock echo", 0);
    frame(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, "R10 erase frame", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'h20, 8'h00, 8'h01, 8'h00, 8'h00, 8'hFF, "R10 program erased", 0);
    frame(8'hA0, 8'h00, 8'h3F, 8'h00, 8'h00, 8'hFF, "R10 data erased", 0);
    frame(8'hC0, 8'h00, 8'h03, 8'h12, 8'h00, 8'h00, "R12 write returns zero", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h12, "R9 data read", 0);
    frame(8'hC0, 8'h00, 8'h03, 8'h34, 8'h00, 8'h00, "R9 data rewrite", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h34, "R9 data replaced", 0);
    frame(8'h40, 8'h00, 8'h05, 8'h0F, 8'h00, 8'h00, "R8 program write 1", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'h40, 8'h00, 8'h05, 8'h3C, 8'h00, 8'h00, "R8 program write 2", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'h20, 8'h00, 8'h05, 8'h00, 8'h00, 8'h0C, "R8 program AND", 0);
    frame(8'h28, 8'h00, 8'h05, 8'h00, 8'h00, 8'hFF, "R7 high byte untouched", 0);
    frame(8'h48, 8'h01, 8'hFF, 8'hA5, 8'h00, 8'h00, "R8 high write", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'h28, 8'h01, 8'hFF, 8'h00, 8'h00, 8'hA5, "R7 top word", 0);
    frame(8'h28, 8'h03, 8'hFF, 8'h00, 8'h00, 8'hA5, "R7 address wrap", 0);
    frame(8'hA0, 8'h00, 8'h43, 8'h00, 8'h00, 8'h34, "R9 address wrap", 0);
    // R11: second write lands inside busy window
    frame(8'hC0, 8'h00, 8'h10, 8'h55, 8'h00, 8'h00, "R11 first write", 0);
    frame(8'hC0, 8'h00, 8'h10, 8'hAA, 8'h00, 8'h00, "R11 blocked write", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h55, "R11 blocked write dropped", 0);
    frame(8'hC0, 8'h00, 8'h11, 8'h66, 8'h00, 8'h00, "R11 write", 0);
    frame(8'hA0, 8'h00, 8'h11, 8'h00, 8'h00, 8'h66, "R11 read while busy", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h34, "R5 short pulse ignored", 1);
    // R1: close the session in the middle of a read
    shift_bits(32'hA0003F00, 24, 0, cap);
    sck = 1'b0;
    repeat (LOW) @(negedge clk);
    check(miso === 1'b1, "R12 read byte on miso", {31'b0, miso}, 32'h1);
    prog_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(miso === 1'b0, "R1 session end", {31'b0, miso}, 32'h0);
    repeat (10) @(negedge clk);

    // session 2: locked until unlocked
    prog_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    frame(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, "R2 locked erase", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'hC0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, "R2 locked write", 0);
    repeat (WAIT_WR) @(negedge clk);
    frame(8'hA0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, "R2 locked read", 0);
    frame(8'hAC, 8'h54, 8'h00, 8'h00, 8'h00, 8'h00, "R6 wrong key no echo", 0);
    frame(8'hA0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, "R6 wrong key keeps lock", 0);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 8'h53, 8'h00, "R6 unlock again", 0);
    frame(8'hA0, 8'h00, 8'h03, 8'h00, 8'h00, 8'h34, "R2 locked write ignored", 0);
    frame(8'h20, 8'h00, 8'h05, 8'h00, 8'h00, 8'h0C, "R2 locked erase ignored", 0);
    frame(8'h28, 8'h00, 8'h05, 8'h00, 8'h00, 8'hFF, "R4 bit order", 0);
    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule